// File: doc/BRIEF.md
# Key Matrix Scanner with Debounce

This block walks a switch matrix of eight row inputs by fourteen column outputs and turns every debounced key change into a one-byte code. At any time after reset it drives exactly one column low, which is modelled as an output-enable bit. The row inputs idle high, and a pressed key at the crossing of the driven column pulls its row low. The block advances to the next column on each pulse of `tick`. `tick` comes from a shared timebase, so the real dwell time of about half a millisecond can be scaled down for simulation.

Each key has its own stable state and a small counter. A change is accepted once it has been seen on `DEB_SCANS` consecutive visits to its column. An accepted press yields a make code and an accepted release yields a break code. Keys are independent, which gives n-key rollover.

A new closure that is first seen within `WINDOW_TICKS` ticks of another new closure is rejected. In that case `keyErr` pulses, and neither key produces a code for that press or for its release. The earlier key is covered too, provided it has not been accepted yet. Codes leave through a ready/valid port backed by a small FIFO. When the FIFO is full, the scan pauses so that no change is lost. `keyHeld` tells power control that a key is down. `DEB_SCANS` must be at least 2.

Top module: `kbd_matrix_scanner`

## Requirements
- R1: While reset is held and after it is released, before the first tick: `codeValid`=0, `keyErr`=0, `keyHeld`=0, and `colOe` drives column 0 only (value 1).
- R2: After reset, exactly one bit of `colOe` is set. Each accepted tick moves it to the next higher column, and it wraps from column 13 back to 0.
- R3: A make code has bit 7 = 0, and bits 6:0 hold col*8+row+1 (col 0..13, row 0..7, giving 01h..70h).
- R4: A release is reported as the make code of that key with bit 7 set (make | 80h).
- R5: A change is reported only after `DEB_SCANS` consecutive column visits see it. A press that lasts a single visit gives no code.
- R6: Keys are independent. While keys are held, a further key still reports its make. Releasing one held key reports only that key's break.
- R7: A new closure first seen within `WINDOW_TICKS` ticks of the previous new closure pulses `keyErr` for one cycle. Neither key then reports a make, or a later break.
- R8: Two new closures in the same column at the same visit count as near-simultaneous and are handled as in R7.
- R9: `keyHeld` is 1 while any key is in the debounced pressed state, rejected keys included, and 0 once all keys are released.
- R10: Codes leave in the order they were produced, through `codeValid`/`codeReady`. While `codeValid` is high and `codeReady` is low, `codeData` holds. A full FIFO freezes the scan (`colOe` stays put) and no code is dropped.
- R11: After rejected keys are released and debounced, a later single press of the same key is reported normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase pulse, one column step each |
| rowIn | input | ROWS | Row inputs, low = key closed on the driven column |
| colOe | output | COLS | Column drive enables, 1 = column pulled low |
| codeValid | output | 1 | A key code is offered |
| codeReady | input | 1 | Downstream accepts the code |
| codeData | output | 8 | Key code, bit 7 set for a break |
| keyErr | output | 1 | One-cycle pulse on a rejected near-simultaneous closure |
| keyHeld | output | 1 | At least one debounced key is pressed |

## Verification
The hardest situation to reach from the ports is two closures whose first sightings fall inside the rejection window. This is hard because the spacing depends on where the scan stands when the keys go down. The bench watches `colOe` until column 0 is driven and only then closes keys in columns 2 and 3. Their first sightings are therefore one tick apart. The same-column case is exercised by closing two rows at once.

The frozen scan is reached by holding `codeReady` low until four codes fill the FIFO. The bench then checks that `colOe` stops moving while a third key waits.

// File: rtl/kbd_scan_pkg.sv
package kbd_scan_pkg;
  localparam int CODE_W = 8;

  // strobes from scan control to the datapath
  typedef struct packed {
    logic latch;     // capture rows of the column just dwelt on
    logic rowValid;  // evaluate one key this cycle
  } scanStrobe_t;
endpackage

// File: rtl/kbd_scan_ctrl.sv
module kbd_scan_ctrl
  import kbd_scan_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 14
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    tick,
  input  logic                    stall,
  output scanStrobe_t             strobe,
  output logic [$clog2(COLS)-1:0] sweepCol,
  output logic [$clog2(ROWS)-1:0] rowIdx,
  output logic [COLS-1:0]         colOe
);
  localparam int COL_W = $clog2(COLS);
  localparam int ROW_W = $clog2(ROWS);

  logic [COL_W-1:0] driveCol;
  logic             sweeping;

  always_comb begin
    strobe.latch    = tick && !sweeping;
    strobe.rowValid = sweeping && !stall;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      driveCol <= '0;
      sweepCol <= '0;
      rowIdx   <= '0;
      sweeping <= 1'b0;
    end else if (strobe.latch) begin
      sweeping <= 1'b1;
      sweepCol <= driveCol;
      rowIdx   <= '0;
      driveCol <= (driveCol == COL_W'(COLS - 1)) ? '0 : driveCol + COL_W'(1);
    end else if (strobe.rowValid) begin
      rowIdx <= rowIdx + ROW_W'(1);
      if (rowIdx == ROW_W'(ROWS - 1)) sweeping <= 1'b0;
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_colEn
    assign colOe[c] = (driveCol == COL_W'(c));
  end

  // R2: a single column driven at all times out of reset
  p_one_col_r2: assert property (@(posedge clk) disable iff (!rstN)
    $countones(colOe) == 1);

  // R10: no column step while a sweep is held by backpressure
  p_freeze_r10: assert property (@(posedge clk) disable iff (!rstN)
    (sweeping && stall) |=> $stable(colOe));
endmodule

// File: rtl/kbd_scan_datapath.sv
module kbd_scan_datapath
  import kbd_scan_pkg::*;
#(
  parameter int ROWS         = 8,
  parameter int COLS         = 14,
  parameter int DEB_SCANS    = 3,
  parameter int WINDOW_TICKS = 10
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ROWS-1:0]         rowIn,
  input  scanStrobe_t             strobe,
  input  logic [$clog2(COLS)-1:0] sweepCol,
  input  logic [$clog2(ROWS)-1:0] rowIdx,
  output logic                    push,
  output logic [CODE_W-1:0]       pushCode,
  output logic                    keyErr,
  output logic                    keyHeld
);
  localparam int KEYS  = ROWS * COLS;
  localparam int KEY_W = $clog2(KEYS);
  localparam int CNT_W = $clog2(DEB_SCANS + 1);
  localparam int WIN_W = $clog2(WINDOW_TICKS + 1);

  logic [ROWS-1:0]  rowSync1, rowSync2, rowLatch;
  logic [KEYS-1:0]  stable;
  logic [KEYS-1:0]  mute;
  logic [CNT_W-1:0] cnt [KEYS];
  logic [WIN_W-1:0] winCnt;
  logic [KEY_W-1:0] lastKey;

  logic [KEY_W-1:0] keyIdx;
  logic             pressedRaw, differs, accept, newClosure, collide;

  always_comb begin
    keyIdx     = KEY_W'(sweepCol) * KEY_W'(ROWS) + KEY_W'(rowIdx);
    pressedRaw = !rowLatch[rowIdx];
    differs    = pressedRaw != stable[keyIdx];
    accept     = strobe.rowValid && differs && (cnt[keyIdx] == CNT_W'(DEB_SCANS - 1));
    newClosure = strobe.rowValid && pressedRaw && !stable[keyIdx] && (cnt[keyIdx] == '0);
    collide    = newClosure && (winCnt != '0);
    push       = accept && !mute[keyIdx];
    pushCode   = {!pressedRaw, 7'(keyIdx) + 7'd1};
    keyHeld    = |stable;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowSync1 <= '1;
      rowSync2 <= '1;
      rowLatch <= '1;
      stable   <= '0;
      mute     <= '0;
      winCnt   <= '0;
      lastKey  <= '0;
      keyErr   <= 1'b0;
      for (int k = 0; k < KEYS; k++) cnt[k] <= '0;
    end else begin
      rowSync1 <= rowIn;
      rowSync2 <= rowSync1;
      keyErr   <= collide;
      if (strobe.latch) begin
        rowLatch <= rowSync2;
        if (winCnt != '0) winCnt <= winCnt - WIN_W'(1);
      end
      if (newClosure) begin
        winCnt  <= WIN_W'(WINDOW_TICKS);
        lastKey <= keyIdx;
      end
      if (strobe.rowValid) begin
        if (!differs) begin
          cnt[keyIdx] <= '0;
          if (!pressedRaw) mute[keyIdx] <= 1'b0;
        end else if (accept) begin
          stable[keyIdx] <= pressedRaw;
          cnt[keyIdx]    <= '0;
          if (!pressedRaw) mute[keyIdx] <= 1'b0;
        end else begin
          cnt[keyIdx] <= cnt[keyIdx] + CNT_W'(1);
        end
        if (collide) begin
          mute[keyIdx] <= 1'b1;
          if (!stable[lastKey]) mute[lastKey] <= 1'b1;
        end
      end
    end
  end

  // R3: every issued code points at a real matrix position
  p_code_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    push |-> (pushCode[6:0] >= 7'd1 && 32'(pushCode[6:0]) <= KEYS));

  // R7: an error pulse follows a closure that restarted the window
  p_err_window_r7: assert property (@(posedge clk) disable iff (!rstN)
    keyErr |-> (winCnt == WIN_W'(WINDOW_TICKS)));
endmodule

// File: rtl/kbd_code_fifo.sv
module kbd_code_fifo
  import kbd_scan_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic [CODE_W-1:0] inData,
  output logic              full,
  output logic              outValid,
  input  logic              outReady,
  output logic [CODE_W-1:0] outData
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CODE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic              pop;

  always_comb begin
    full     = (count == CNT_W'(DEPTH));
    outValid = (count != '0);
    outData  = mem[rdPtr];
    pop      = outValid && outReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (push) begin
        mem[wrPtr] <= inData;
        wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + PTR_W'(1);
      end
      if (pop) rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + PTR_W'(1);
      case ({push, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  // R10: the scan must never offer a code the buffer cannot hold
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rstN)
    push |-> !full);

  // R10: an offered code stays put until taken
  p_hold_code_r10: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));
endmodule

// File: rtl/kbd_matrix_scanner.sv
module kbd_matrix_scanner
  import kbd_scan_pkg::*;
#(
  parameter int ROWS         = 8,
  parameter int COLS         = 14,
  parameter int DEB_SCANS    = 3,
  parameter int WINDOW_TICKS = 10,
  parameter int FIFO_DEPTH   = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            tick,
  input  logic [ROWS-1:0] rowIn,
  output logic [COLS-1:0] colOe,
  output logic            codeValid,
  input  logic            codeReady,
  output logic [7:0]      codeData,
  output logic            keyErr,
  output logic            keyHeld
);
  scanStrobe_t             strobe;
  logic [$clog2(COLS)-1:0] sweepCol;
  logic [$clog2(ROWS)-1:0] rowIdx;
  logic                    push, full;
  logic [CODE_W-1:0]       pushCode;

  kbd_scan_ctrl #(.ROWS(ROWS), .COLS(COLS)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .stall(full),
    .strobe(strobe), .sweepCol(sweepCol), .rowIdx(rowIdx), .colOe(colOe)
  );

  kbd_scan_datapath #(
    .ROWS(ROWS), .COLS(COLS), .DEB_SCANS(DEB_SCANS), .WINDOW_TICKS(WINDOW_TICKS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .rowIn(rowIn), .strobe(strobe),
    .sweepCol(sweepCol), .rowIdx(rowIdx), .push(push), .pushCode(pushCode),
    .keyErr(keyErr), .keyHeld(keyHeld)
  );

  kbd_code_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rstN(rstN), .push(push), .inData(pushCode), .full(full),
    .outValid(codeValid), .outReady(codeReady), .outData(codeData)
  );
endmodule

// File: tb/kbd_matrix_scanner_tb.sv
module kbd_matrix_scanner_tb;
  localparam int ROWS = 8;
  localparam int COLS = 14;
  localparam int TICK_GAP = 16;
  localparam int SCAN_CYC = COLS * TICK_GAP;

  // {col[3:0], row[3:0], expected make code}
  localparam logic [15:0] VEC [6] = '{16'h0001, 16'hD770, 16'h1009,
                                       16'h0708, 16'h6334, 16'hC566};

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                 rstN, tick, codeReady, codeValid, keyErr, keyHeld;
  logic [ROWS-1:0]      rowIn;
  logic [COLS-1:0]      colOe;
  logic [7:0]           codeData;
  logic [ROWS*COLS-1:0] keyDown;
  logic                 tickEn;

  int nChecks = 0, nFail = 0, rxN = 0, errN = 0, tickNum = 0;
  logic [7:0] rx [128];

  kbd_matrix_scanner u_dut (
    .clk(clk), .rstN(rstN), .tick(tick), .rowIn(rowIn), .colOe(colOe),
    .codeValid(codeValid), .codeReady(codeReady), .codeData(codeData),
    .keyErr(keyErr), .keyHeld(keyHeld)
  );

  // matrix model: a closed key pulls its row low when its column is driven
  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      rowIn[r] = 1'b1;
      for (int c = 0; c < COLS; c++)
        if (colOe[c] && keyDown[c*ROWS+r]) rowIn[r] = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (codeValid && codeReady) begin
        if (rxN < 128) rx[rxN] = codeData;
        rxN++;
      end
      if (keyErr) errN++;
    end
  end

  initial begin
    tick = 1'b0;
    wait (tickEn);
    forever begin
      repeat (TICK_GAP - 1) @(negedge clk);
      tick = 1'b1;
      tickNum++;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic setKey(input int c, input int r, input bit v);
    keyDown[c*ROWS+r] = v;
  endtask

  task automatic waitScans(input int n);
    repeat (n * SCAN_CYC) @(negedge clk);
  endtask

  task automatic waitCol(input int c);
    @(negedge clk);
    while (!colOe[c]) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    finishRun();
  end

  initial begin
    int base, e0;
    logic [13:0] frozen;
    rstN = 1'b0; tickEn = 1'b0; codeReady = 1'b1; keyDown = '0;
    repeat (5) @(negedge clk);
    // R1 during reset
    chk(!codeValid, "R1", "valid in reset", int'(codeValid), 0);
    chk(!keyHeld && !keyErr, "R1", "held/err in reset", int'({keyHeld, keyErr}), 0);
    chk(colOe == 14'h1, "R1", "column in reset", int'(colOe), 1);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(colOe == 14'h1 && !codeValid, "R1", "after reset", int'(colOe), 1);

    // R2: column order and wrap
    tickEn = 1'b1;
    for (int i = 0; i < 15; i++) begin
      wait (tickNum == i + 1);
      repeat (3) @(negedge clk);
      chk(colOe == 14'(1 << ((i + 1) % COLS)), "R2", "column step",
          int'(colOe), 1 << ((i + 1) % COLS));
    end

    // vector table: R3 make, R4 break, R9 held
    for (int v = 0; v < 6; v++) begin
      int c, r;
      logic [7:0] mk;
      c  = int'(VEC[v][15:12]);
      r  = int'(VEC[v][11:8]);
      mk = VEC[v][7:0];
      base = rxN;
      setKey(c, r, 1'b1);
      waitScans(4);
      chk(rxN == base + 1 && rx[base] == mk, "R3", "make code", int'(rx[base]), int'(mk));
      chk(keyHeld, "R9", "held while pressed", int'(keyHeld), 1);
      setKey(c, r, 1'b0);
      waitScans(4);
      chk(rxN == base + 2 && rx[base+1] == (mk | 8'h80), "R4", "break code",
          int'(rx[base+1]), int'(mk | 8'h80));
      chk(!keyHeld, "R9", "held after release", int'(keyHeld), 0);
    end

    // R6 rollover
    base = rxN;
    setKey(2, 1, 1'b1); waitScans(4);
    setKey(9, 4, 1'b1); waitScans(4);
    chk(rxN == base + 2 && rx[base] == 8'h12 && rx[base+1] == 8'h4D, "R6",
        "second make while held", int'(rx[base+1]), 'h4D);
    setKey(2, 1, 1'b0); waitScans(4);
    chk(rxN == base + 3 && rx[base+2] == 8'h92, "R6", "only released key breaks",
        int'(rx[base+2]), 'h92);
    setKey(9, 4, 1'b0); waitScans(4);
    chk(rxN == base + 4 && rx[base+3] == 8'hCD, "R6", "last break", int'(rx[base+3]), 'hCD);

    // R7: closures in adjacent columns one tick apart
    base = rxN; e0 = errN;
    waitCol(0);
    setKey(2, 1, 1'b1); setKey(3, 6, 1'b1);
    waitScans(5);
    chk(errN == e0 + 1, "R7", "error pulses", errN - e0, 1);
    chk(rxN == base, "R7", "no make for rejected keys", rxN - base, 0);
    chk(keyHeld, "R9", "rejected keys count as held", int'(keyHeld), 1);
    setKey(2, 1, 1'b0); setKey(3, 6, 1'b0);
    waitScans(5);
    chk(rxN == base, "R7", "no break for rejected keys", rxN - base, 0);
    chk(!keyHeld, "R9", "released after rejection", int'(keyHeld), 0);
    // R11: same key works again
    setKey(2, 1, 1'b1); waitScans(4);
    setKey(2, 1, 1'b0); waitScans(4);
    chk(rxN == base + 2 && rx[base] == 8'h12 && rx[base+1] == 8'h92, "R11",
        "key usable after rejection", int'(rx[base]), 'h12);

    // R8: two rows of one column together
    base = rxN; e0 = errN;
    setKey(5, 0, 1'b1); setKey(5, 6, 1'b1);
    waitScans(5);
    chk(errN == e0 + 1 && rxN == base, "R8", "same-column rejection", errN - e0, 1);
    setKey(5, 0, 1'b0); setKey(5, 6, 1'b0);
    waitScans(5);
    chk(rxN == base, "R8", "no break after same-column rejection", rxN - base, 0);

    // R5: a closure seen on one visit only
    base = rxN;
    waitCol(7);
    setKey(7, 2, 1'b1);
    repeat (TICK_GAP + 4) @(negedge clk);
    setKey(7, 2, 1'b0);
    waitScans(5);
    chk(rxN == base && !keyHeld, "R5", "bounce filtered", rxN - base, 0);

    // R10: backpressure, order and frozen scan
    base = rxN;
    codeReady = 1'b0;
    setKey(0, 3, 1'b1); waitScans(4);
    setKey(0, 3, 1'b0); waitScans(4);
    setKey(10, 2, 1'b1); waitScans(4);
    setKey(10, 2, 1'b0); waitScans(4);
    chk(codeValid && rxN == base, "R10", "codes waiting", int'(codeValid), 1);
    setKey(4, 4, 1'b1);
    frozen = colOe;
    waitScans(2);
    chk(colOe == frozen, "R10", "scan frozen while full", int'(colOe), int'(frozen));
    codeReady = 1'b1;
    waitScans(5);
    chk(rxN == base + 5, "R10", "no code lost", rxN - base, 5);
    chk(rx[base] == 8'h04 && rx[base+1] == 8'h84 && rx[base+2] == 8'h53 &&
        rx[base+3] == 8'hD3, "R10", "order kept", int'(rx[base+2]), 'h53);
    chk(rx[base+4] == 8'h25, "R10", "make after resume", int'(rx[base+4]), 'h25);
    setKey(4, 4, 1'b0); waitScans(4);
    chk(rxN == base + 6 && rx[base+5] == 8'hA5, "R4", "break after resume",
        int'(rx[base+5]), 'hA5);

    finishRun();
  end
endmodule